// File: doc/BRIEF.md
# Glitch-Free Two-Source Clock Selector

This block drives one output clock from one of two reference clocks. A request line asks it to move to the other source. Each move is made so that the output never shows a shortened high or low phase. The old source is gated off on one of its own falling edges. Only after that does the new source's gate open, on a falling edge of the new clock. A two-bit status output shows which source drives the output at any moment. During a handoff the status is zero, because neither source drives the output then.

Each source has its own lane, clocked by that source. A lane holds a small state machine with four states:

- **IDLE**: the lane does not own the output.
- **WAIT**: ownership has arrived and the lane waits for its clock to be usable.
- **ACTIVE**: the gate is open.
- **DRAIN**: the gate is closing.

Ownership passes between the lanes as a toggle token. Each toggle crosses into the other domain through a two-flop synchronizer. The transitions are:

- IDLE→WAIT when a token toggle arrives.
- WAIT→ACTIVE when the lane's bad flag is low and the peer's gate, as seen through the synchronizer, is closed.
- ACTIVE→DRAIN on a request rising edge, or on a pending edge.
- DRAIN→IDLE once the gate has closed. The lane sends its token toggle on this transition.

A per-source bad flag marks a source as unusable. A lane in WAIT stays there for as long as its flag is set.

Top module: `refclk_switch`

## Requirements
- R1: While `rst` is high both `drv_src` bits are 0. After `rst` falls, source A (`clk_a`) is selected, and `drv_src` reads 2'b01 within a few `clk_a` cycles. Any pending request is cleared by reset.
- R2: Each rising edge of `swap_req` moves the output to the source that is not currently selected.
- R3: A falling edge of `swap_req`, or a level held high, causes no switch.
- R4: `drv_src` bit 0 means `clk_a` drives `clk_out`, and bit 1 means `clk_b` drives it. At most one bit is ever set. During a handoff the value is 2'b00.
- R5: A source's gate changes only while that source is low. No high or low phase of `clk_out` is shorter than the shorter half-period of the two sources.
- R6: The old source is gated off before the new source is enabled, and the new source's enable takes effect on a falling edge of the new source.
- R7: While the target source's bad flag (`bad_a` or `bad_b`) is high, the switch halts after the old source is gated off. `drv_src` stays at 2'b00 and `clk_out` stays low. The switch completes once the flag falls.
- R8: When `drv_src` has one bit set, `clk_out` follows that source: it is high while that source is high and low while it is low.
- R9: A `swap_req` rising edge that arrives while the target lane is waiting is held. Once the pending switch completes, the held edge starts a switch back to the other source.
- R10: A bad flag on the source being left has no effect on the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | First reference clock, selected after reset |
| clk_b | input | 1 | Second reference clock |
| rst | input | 1 | Asynchronous reset, active high |
| swap_req | input | 1 | Switch request; each rising edge moves the output to the other source |
| bad_a | input | 1 | High when `clk_a` must not be used |
| bad_b | input | 1 | High when `clk_b` must not be used |
| clk_out | output | 1 | Gated output clock |
| drv_src | output | 2 | Source now driving `clk_out` (bit 0 = A, bit 1 = B) |

## Verification
A switch finishes a fixed number of edges after the request rises. The old source needs about four of its own cycles: synchronization, edge detection, then DRAIN and gate-off. The new source then needs about four and a half of its own cycles: token synchronization, WAIT, ACTIVE, and the falling-edge gate. With 10 ns and 14 ns periods this is about 110 ns, so the bench samples `drv_src` 400 ns after each request edge, well past that point. After a bad flag falls, the held switch needs three to four cycles of the target clock, and the bench waits 400 to 600 ns before sampling. Pulse widths on `clk_out` are measured at every edge. The following checks sample `clk_out` 1 ns after each edge of the selected source, so they never land on an edge.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;
    typedef enum logic [1:0] {
        LN_IDLE,
        LN_WAIT,
        LN_ACTIVE,
        LN_DRAIN
    } lane_state_t;

    localparam int NUM_SRC = 2;
endpackage

// File: rtl/clksw_sync.sv
`timescale 1ns/1ps
module clksw_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/clksw_lane.sv
`timescale 1ns/1ps
module clksw_lane
    import clksw_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter bit OWN_AT_RESET = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic req_async,
    input  logic bad_async,
    input  logic peer_gate_async,
    input  logic peer_pass_async,
    output logic gate_q,
    output logic pass_q
);
    lane_state_t state_q, state_d;
    logic req_s, req_d, bad_s, peer_on_s, ptgl_s, ptgl_d;
    logic pend_q, pend_d, pass_d, en_want;
    logic req_rise, tok_in;

    clksw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_sync (
        .clk(clk), .rst(rst), .d(req_async), .q(req_s));
    clksw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_bad_sync (
        .clk(clk), .rst(rst), .d(bad_async), .q(bad_s));
    clksw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_peer_gate_sync (
        .clk(clk), .rst(rst), .d(peer_gate_async), .q(peer_on_s));
    clksw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_peer_pass_sync (
        .clk(clk), .rst(rst), .d(peer_pass_async), .q(ptgl_s));

    assign req_rise = req_s & ~req_d;
    assign tok_in   = ptgl_s ^ ptgl_d;

    // state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= OWN_AT_RESET ? LN_ACTIVE : LN_IDLE;
            pend_q  <= 1'b0;
            pass_q  <= 1'b0;
            req_d   <= 1'b0;
            ptgl_d  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            pass_q  <= pass_d;
            req_d   <= req_s;
            ptgl_d  <= ptgl_s;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        pass_d  = pass_q;
        unique case (state_q)
            LN_IDLE: begin
                if (tok_in) state_d = LN_WAIT;
            end
            LN_WAIT: begin
                if (req_rise) pend_d = 1'b1;
                if (!bad_s && !peer_on_s) state_d = LN_ACTIVE;
            end
            LN_ACTIVE: begin
                if (req_rise || pend_q) begin
                    state_d = LN_DRAIN;
                    pend_d  = 1'b0;
                end
            end
            LN_DRAIN: begin
                if (!gate_q) begin
                    state_d = LN_IDLE;
                    pass_d  = ~pass_q;
                end
            end
            default: state_d = LN_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        en_want = (state_q == LN_ACTIVE);
    end

    // gate moves only while this clock is low
    always_ff @(negedge clk or posedge rst) begin
        if (rst) begin
            gate_q <= 1'b0;
        end else begin
            gate_q <= en_want;
        end
    end
endmodule

// File: rtl/refclk_switch.sv
`timescale 1ns/1ps
module refclk_switch
    import clksw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_a,
    input  logic       clk_b,
    input  logic       rst,
    input  logic       swap_req,
    input  logic       bad_a,
    input  logic       bad_b,
    output logic       clk_out,
    output logic [1:0] drv_src
);
    logic [NUM_SRC-1:0] clk_v, bad_v, gate_v, pass_v;

    assign clk_v = {clk_b, clk_a};
    assign bad_v = {bad_b, bad_a};

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
        clksw_lane #(
            .SYNC_STAGES (SYNC_STAGES),
            .OWN_AT_RESET(i == 0)
        ) u_lane (
            .clk            (clk_v[i]),
            .rst            (rst),
            .req_async      (swap_req),
            .bad_async      (bad_v[i]),
            .peer_gate_async(gate_v[NUM_SRC-1-i]),
            .peer_pass_async(pass_v[NUM_SRC-1-i]),
            .gate_q         (gate_v[i]),
            .pass_q         (pass_v[i])
        );
    end

    assign clk_out = |(clk_v & gate_v);
    assign drv_src = gate_v;
endmodule

// File: rtl/refclk_switch_chk.sv
`timescale 1ns/1ps
module refclk_switch_chk (
    input logic       clk_a,
    input logic       clk_b,
    input logic       rst,
    input logic       bad_b,
    input logic       clk_out,
    input logic [1:0] drv_src
);
    p_onehot_src_r4: assert property (@(posedge clk_a) disable iff (rst)
        $onehot0(drv_src));

    p_onehot_src_b_r4: assert property (@(posedge clk_b) disable iff (rst)
        $onehot0(drv_src));

    p_follow_a_r8: assert property (@(negedge clk_a) disable iff (rst)
        drv_src[0] |-> clk_out);

    p_follow_b_r8: assert property (@(negedge clk_b) disable iff (rst)
        drv_src[1] |-> clk_out);

    p_bad_blocks_b_r7: assert property (@(posedge clk_b) disable iff (rst)
        $rose(drv_src[1]) |-> !$past(bad_b, 3));

    p_new_after_old_r6: assert property (@(posedge clk_b) disable iff (rst)
        $rose(drv_src[1]) |-> !drv_src[0]);

    always @(drv_src[0]) begin
        if (!rst) p_gate_a_low_r5: assert (!clk_a);
    end

    always @(drv_src[1]) begin
        if (!rst) p_gate_b_low_r5: assert (!clk_b);
    end
endmodule

bind refclk_switch refclk_switch_chk u_chk (
    .clk_a  (clk_a),
    .clk_b  (clk_b),
    .rst    (rst),
    .bad_b  (bad_b),
    .clk_out(clk_out),
    .drv_src(drv_src)
);

// File: tb/refclk_switch_bench.sv
`timescale 1ns/1ps
module refclk_switch_bench;
    localparam time CLK_PERIOD   = 10ns;
    localparam time CLK_B_PERIOD = 14ns;
    localparam real MIN_W        = 4.9;
    // entry: {bad_a, bad_b, expected drv_src}
    localparam logic [3:0] VEC [0:3] = '{4'b0010, 4'b0101, 4'b1010, 4'b0001};

    logic clk_a, clk_b, rst, swap_req, bad_a, bad_b;
    logic clk_out;
    logic [1:0] drv_src;
    int checks = 0;
    int errors = 0;
    int short_cnt = 0;
    realtime t_rise = 0.0;
    realtime t_fall = 0.0;

    refclk_switch u_refclk_switch (
        .clk_a(clk_a), .clk_b(clk_b), .rst(rst), .swap_req(swap_req),
        .bad_a(bad_a), .bad_b(bad_b), .clk_out(clk_out), .drv_src(drv_src));

    initial begin
        clk_a = 1'b0;
        forever #(CLK_PERIOD/2) clk_a = ~clk_a;
    end

    initial begin
        clk_b = 1'b0;
        #3ns;
        forever #(CLK_B_PERIOD/2) clk_b = ~clk_b;
    end

    // pulse-width monitor on the output (R5)
    always @(posedge clk_out) begin
        if (!rst && t_fall > 0.0 && ($realtime - t_fall) < MIN_W) short_cnt++;
        t_rise = $realtime;
    end
    always @(negedge clk_out) begin
        if (!rst && t_rise > 0.0 && ($realtime - t_rise) < MIN_W) short_cnt++;
        t_fall = $realtime;
    end

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic pulse_req();
        swap_req = 1'b1;
        #100ns;
        swap_req = 1'b0;
        #100ns;
    endtask

    // R8: output follows the chosen source for ten cycles
    task automatic follow_check(input bit use_b);
        int bad = 0;
        for (int k = 0; k < 10; k++) begin
            if (use_b) @(posedge clk_b); else @(posedge clk_a);
            #1ns;
            if (clk_out !== 1'b1) bad++;
            if (use_b) @(negedge clk_b); else @(negedge clk_a);
            #1ns;
            if (clk_out !== 1'b0) bad++;
        end
        chk("R8 follow", bad, 0);
    endtask

    initial begin
        #1ms;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; swap_req = 1'b0; bad_a = 1'b0; bad_b = 1'b0;
        #35ns;
        rst = 1'b0;
        #100ns;
        chk("R1 reset selects A", int'(drv_src), 1);
        follow_check(1'b0);

        // table walk: R2 switching, R10 bad flag on the source being left
        for (int v = 0; v < 4; v++) begin
            bad_a = VEC[v][3];
            bad_b = VEC[v][2];
            #50ns;
            pulse_req();
            #200ns;
            chk("R2/R10 table", int'(drv_src), int'(VEC[v][1:0]));
            if (v == 0) follow_check(1'b1);
            bad_a = 1'b0;
            bad_b = 1'b0;
        end

        // R3: held level and falling edge do nothing
        swap_req = 1'b1;
        #400ns;
        chk("R2 rise while held", int'(drv_src), 2);
        swap_req = 1'b0;
        #400ns;
        chk("R3 fall no switch", int'(drv_src), 2);

        // R7: target A flagged bad, stall with output silent
        bad_a = 1'b1;
        pulse_req();
        #300ns;
        chk("R7 stall src", int'(drv_src), 0);
        begin
            int hi = 0;
            for (int k = 0; k < 20; k++) begin
                #7ns;
                if (clk_out !== 1'b0) hi++;
            end
            chk("R7 output silent", hi, 0);
        end
        // R9: second edge during wait is held
        pulse_req();
        #100ns;
        chk("R9 still waiting", int'(drv_src), 0);
        bad_a = 1'b0;
        #600ns;
        chk("R9 held edge serviced", int'(drv_src), 2);

        // R7: target B flagged bad
        pulse_req();
        #200ns;
        chk("R2 back to A", int'(drv_src), 1);
        bad_b = 1'b1;
        pulse_req();
        #300ns;
        chk("R7 stall on B", int'(drv_src), 0);
        bad_b = 1'b0;
        #400ns;
        chk("R7 completes on B", int'(drv_src), 2);

        // R1: reset mid-operation
        rst = 1'b1;
        #30ns;
        chk("R1 reset gates off", int'(drv_src), 0);
        rst = 1'b0;
        #150ns;
        chk("R1 reset back to A", int'(drv_src), 1);
        follow_check(1'b0);

        // R5/R6: no runt pulse seen at any point
        chk("R5/R6 pulse widths", short_cnt, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule